// File: doc/BRIEF.md
# Single-Wire Debug Bit Receiver

This block is the receiving half of a target-side debug port that talks to a host over one bidirectional wire. The host owns all timing: it marks the start of every bit by pulling the line low, then either releases it early (a one) or keeps it low past the middle of the bit (a zero). The receiver brings the asynchronous line into the local clock domain and detects those falling edges. It samples the line a fixed number of cycles after each detected edge and shifts the sampled bits into a word register, most significant bit first.

When a full word has been collected, a one-cycle valid strobe accompanies the word. If the host stays silent for too long, an idle watchdog empties the word register, drops any partly received bits and raises a one-cycle timeout pulse. The target never drives the wire while it receives, so the drive-enable output is held low. Word length, sample offset, idle limit and synchronizer depth are all parameters.

Top module: `dbg_wire_rx`

## Requirements
- R1: While reset is asserted, `word_o` is 0, and `word_vld_o`, `timeout_o` and `line_oe_o` are 0.
- R2: `line_oe_o` is 0 in every cycle, so the target never drives the line.
- R3: A 1-to-0 transition on `line_i` that is seen through the synchronizer starts a bit. The bit's value is the synchronized line level exactly `SAMPLE_OFS` clock cycles after the edge that registers that transition. A line that is released early reads as 1. A line that is held low past the sample point reads as 0.
- R4: Sampled bits enter `word_o` at bit 0 and move toward the most significant bit, so the first bit of a word ends up in bit `WORD_W-1`.
- R5: In the cycle after the `WORD_W`-th bit of a word is shifted in, `word_vld_o` is high for exactly one cycle. The bit count then restarts, so the next bit begins a new word.
- R6: A falling edge that arrives while a bit is still waiting for its sample point is ignored. It neither restarts nor shifts the sample timing.
- R7: Once `TIMEOUT_CYC` cycles have passed since the last accepted falling edge, `timeout_o` pulses for one cycle. In that same cycle `word_o` reads 0, and the partial bit count is cleared.
- R8: After a timeout, no further timeout pulse occurs until a new falling edge has been accepted.
- R9: No timeout pulse occurs after reset until the first falling edge has been accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Raw level of the debug wire |
| word_o | output | WORD_W | Shift register contents; first received bit at the MSB |
| word_vld_o | output | 1 | One-cycle strobe when a complete word is in `word_o` |
| timeout_o | output | 1 | One-cycle pulse when the idle limit expires |
| line_oe_o | output | 1 | Drive enable for the wire, always 0 |

## Verification
The bench builds the block with an 8-bit word, a two-flop synchronizer, a 10-cycle sample offset and a 512-cycle idle limit. With these values a full word plus the timeout window fits in a few thousand cycles, so the bench can test real timeouts in both directions. It checks that a timeout clears a partly received word and that a long silence after reset or after a timeout produces no extra pulse. With 16-cycle bits, ones are released after 4 cycles and zeros are held for 13. This puts both levels clearly on either side of the sample point. A glitch that falls inside the sample window changes the decoded bit if it is wrongly accepted.

// File: rtl/dbg_wire_pkg.sv
package dbg_wire_pkg;
   // One sampled bit leaving the bit timer
   typedef struct packed {
      logic stb;
      logic level;
   } bit_evt_t;
endpackage

// File: rtl/dbg_line_sync.sv
module dbg_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_s_o,
   output logic fall_o
);
   localparam int LAST = STAGES - 1;

   logic chain_q [STAGES];
   logic prev_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("dbg_line_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= 1'b1;
               else        chain_q[i] <= line_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= 1'b1;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain_q[LAST];
   end

   assign line_s_o = chain_q[LAST];
   assign fall_o   = prev_q & ~chain_q[LAST];

   // An edge seen now means the line was high one cycle ago
   AST_FALL_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |-> $past(line_s_o)) else $error("fall without prior high"); // R3
endmodule

// File: rtl/dbg_bit_timer.sv
module dbg_bit_timer
   import dbg_wire_pkg::*;
#(
   parameter int SAMPLE_OFS = 10
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     fall_i,
   input  logic     level_i,
   output logic     start_o,
   output bit_evt_t evt_o
);
   localparam int CW = $clog2(SAMPLE_OFS);

   logic          busy_q;
   logic [CW-1:0] cnt_q;

   generate
      if (SAMPLE_OFS < 2) begin : g_bad_ofs
         $error("dbg_bit_timer: SAMPLE_OFS must be at least 2");
      end
   endgenerate

   assign start_o     = fall_i & ~busy_q;
   assign evt_o.stb   = busy_q & (cnt_q == '0);
   assign evt_o.level = level_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start_o) begin
         busy_q <= 1'b1;
         cnt_q  <= CW'(SAMPLE_OFS - 1);
      end else if (busy_q) begin
         if (cnt_q == '0) busy_q <= 1'b0;
         else             cnt_q  <= cnt_q - CW'(1);
      end
   end

   // A bit in flight keeps its window; later edges cannot end it early
   AST_WINDOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != '0) |=> busy_q) else $error("window dropped"); // R6
   AST_ONE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o.stb |=> !evt_o.stb) else $error("double sample"); // R3
endmodule

// File: rtl/dbg_idle_watch.sv
module dbg_idle_watch #(
   parameter int TIMEOUT_CYC = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick_i,
   output logic fire_o,
   output logic tmo_o
);
   localparam int TW = $clog2(TIMEOUT_CYC);

   logic [TW-1:0] cnt_q;
   logic          expired_q;
   logic          tmo_q;

   generate
      if (TIMEOUT_CYC < 2) begin : g_bad_tmo
         $error("dbg_idle_watch: TIMEOUT_CYC must be at least 2");
      end
   endgenerate

   assign fire_o = ~kick_i & ~expired_q & (cnt_q == TW'(TIMEOUT_CYC - 1));
   assign tmo_o  = tmo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         expired_q <= 1'b1;
         tmo_q     <= 1'b0;
      end else begin
         tmo_q <= fire_o;
         if (kick_i) begin
            cnt_q     <= '0;
            expired_q <= 1'b0;
         end else if (fire_o) begin
            expired_q <= 1'b1;
         end else if (!expired_q) begin
            cnt_q <= cnt_q + TW'(1);
         end
      end
   end

   AST_TMO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_o |=> !tmo_o) else $error("timeout longer than a cycle"); // R8
   AST_TMO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_o |-> !$past(kick_i)) else $error("timeout right after edge"); // R7
endmodule

// File: rtl/dbg_wire_rx.sv
module dbg_wire_rx
   import dbg_wire_pkg::*;
#(
   parameter int WORD_W      = 8,
   parameter int SAMPLE_OFS  = 10,
   parameter int TIMEOUT_CYC = 512,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_i,
   output logic [WORD_W-1:0] word_o,
   output logic              word_vld_o,
   output logic              timeout_o,
   output logic              line_oe_o
);
   localparam int BCW = $clog2(WORD_W);

   generate
      if (WORD_W < 2) begin : g_bad_w
         $error("dbg_wire_rx: WORD_W must be at least 2");
      end
      if (SAMPLE_OFS >= TIMEOUT_CYC) begin : g_bad_ratio
         $error("dbg_wire_rx: SAMPLE_OFS must be below TIMEOUT_CYC");
      end
   endgenerate

   logic     line_s, fall, start, fire;
   bit_evt_t evt;

   logic [WORD_W-1:0] shift_q;
   logic [BCW-1:0]    bits_q;
   logic              vld_q;

   dbg_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .line_i(line_i),
      .line_s_o(line_s), .fall_o(fall)
   );

   dbg_bit_timer #(.SAMPLE_OFS(SAMPLE_OFS)) u_timer (
      .clk(clk), .rst_n(rst_n), .fall_i(fall), .level_i(line_s),
      .start_o(start), .evt_o(evt)
   );

   dbg_idle_watch #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_watch (
      .clk(clk), .rst_n(rst_n), .kick_i(start),
      .fire_o(fire), .tmo_o(timeout_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q <= '0;
         bits_q  <= '0;
         vld_q   <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         if (fire) begin
            shift_q <= '0;
            bits_q  <= '0;
         end else if (evt.stb) begin
            shift_q <= {shift_q[WORD_W-2:0], evt.level};
            if (bits_q == BCW'(WORD_W - 1)) begin
               bits_q <= '0;
               vld_q  <= 1'b1;
            end else begin
               bits_q <= bits_q + BCW'(1);
            end
         end
      end
   end

   assign word_o     = shift_q;
   assign word_vld_o = vld_q;
   assign line_oe_o  = 1'b0;

   AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld_o |=> !word_vld_o) else $error("valid held"); // R5
   AST_TMO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> (word_o == '0 && bits_q == '0)) else $error("timeout left data"); // R7
   AST_VLD_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld_o |-> $past(evt.stb)) else $error("valid without sample"); // R5
endmodule

// File: tb/test_dbg_wire_rx.sv
`timescale 1ns/1ps
module test_dbg_wire_rx;
   localparam int W   = 8;
   localparam int OFS = 10;
   localparam int TMO = 512;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         line = 1'b1;
   logic [W-1:0] word;
   logic         vld, tmo, oe;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   dbg_wire_rx #(.WORD_W(W), .SAMPLE_OFS(OFS), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) i_dbg_wire_rx (
      .clk(clk), .rst_n(rst_n), .line_i(line),
      .word_o(word), .word_vld_o(vld), .timeout_o(tmo), .line_oe_o(oe)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit           hist[$];
   int           m, samp_at, last_acc;
   bit           m_expired, e_vld, e_tmo;
   int           nbits;
   logic [W-1:0] m_word;

   always @(posedge clk) begin
      if (!rst_n) begin
         hist = {1'b1, 1'b1, 1'b1};
         m = 0; samp_at = -1; last_acc = 0; m_expired = 1'b1;
         nbits = 0; m_word = '0; e_vld = 1'b0; e_tmo = 1'b0;
      end else begin
         bit fell, acc, take;
         m++;
         e_vld = 1'b0;
         e_tmo = 1'b0;
         fell = hist[2] && !hist[1];
         acc  = fell && (m > samp_at);
         take = (m == samp_at);
         if (acc) begin
            samp_at = m + OFS;
            last_acc = m;
            m_expired = 1'b0;
         end else if (!m_expired && m == last_acc + TMO) begin
            e_tmo = 1'b1;
            m_expired = 1'b1;
            m_word = '0;
            nbits = 0;
         end
         if (take && !e_tmo) begin
            m_word = {m_word[W-2:0], hist[1]};
            nbits++;
            if (nbits == W) begin
               nbits = 0;
               e_vld = 1'b1;
            end
         end
         hist.push_front(line);
         hist = hist[0:2];
      end
   end

   // Per-cycle comparison plus monitors for directed checks
   int           n_words = 0;
   int           n_tmo = 0;
   logic [W-1:0] got_word = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         chk(word == m_word, "R4 word", int'(word), int'(m_word));
         chk(vld == e_vld, "R5 valid", int'(vld), int'(e_vld));
         chk(tmo == e_tmo, "R7 timeout", int'(tmo), int'(e_tmo));
         chk(oe == 1'b0, "R2 drive", int'(oe), 0);
         if (vld) begin n_words++; got_word = word; end
         if (tmo) n_tmo++;
      end
   end

   // ---------------- stimulus ----------------
   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input bit b);
      @(negedge clk) line = 1'b0;
      idle(b ? 4 : 13);
      line = 1'b1;
      idle(b ? 11 : 2);
   endtask

   task automatic send_glitch0();
      @(negedge clk) line = 1'b0;
      idle(3);
      line = 1'b1;
      idle(2);
      line = 1'b0;
      idle(8);
      line = 1'b1;
      idle(2);
   endtask

   task automatic send_word(input logic [W-1:0] v);
      for (int i = W - 1; i >= 0; i--) send_bit(v[i]);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int w0;
      idle(3);
      // R1: outputs quiet in reset
      chk(word == '0 && !vld && !tmo && !oe, "R1 reset", int'({word, vld, tmo, oe}), 0);
      @(negedge clk) rst_n = 1'b1;

      // R9: no timeout without a first edge
      idle(700);
      chk(n_tmo == 0, "R9 no early timeout", n_tmo, 0);

      // R3: mixed ones and zeros decode
      send_word(8'hA5);
      idle(20);
      chk(got_word == 8'hA5 && n_words == 1, "R3 decode", int'(got_word), 'hA5);

      // R4: first bit lands at the MSB
      send_word(8'h01);
      idle(20);
      chk(got_word == 8'h01, "R4 order", int'(got_word), 'h01);

      // R5: back-to-back words restart the count
      w0 = n_words;
      send_word(8'hF0);
      send_word(8'h0F);
      idle(20);
      chk(n_words == w0 + 2, "R5 word count", n_words, w0 + 2);
      chk(got_word == 8'h0F, "R5 second word", int'(got_word), 'h0F);

      // R6: mid-window glitch is ignored
      send_bit(1); send_glitch0(); send_bit(1); send_glitch0();
      send_bit(1); send_bit(1);    send_glitch0(); send_bit(1);
      idle(20);
      chk(got_word == 8'hAD, "R6 glitch", int'(got_word), 'hAD);

      // R7: timeout clears partial bits and the word
      send_bit(1); send_bit(1); send_bit(1);
      idle(600);
      chk(n_tmo == 1, "R7 timeout pulse", n_tmo, 1);
      chk(word == '0, "R7 word cleared", int'(word), 0);
      send_word(8'h3C);
      idle(20);
      chk(got_word == 8'h3C, "R7 partial cleared", int'(got_word), 'h3C);

      // R8: one pulse per silence
      idle(1300);
      chk(n_tmo == 2, "R8 saturate", n_tmo, 2);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule